// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a down-counting timer behind a small synchronous register port. Software sets a start value, chooses a clock divider and a run mode, and enables the count. The counter steps down by one each time the divider has counted through its period. When it steps from one to zero the timer expires. Expiry sets a sticky status flag. In one-shot mode the count then stays at zero. In auto-reload mode the start value is copied back in and counting goes on.

The interrupt output pulses for a single cycle only when the status flag changes from clear to set. Software clears the flag by writing a one to it. The register port has no handshake. A write takes effect at the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr` and the current register state.

Top module: `cdt_timer`

## Requirements
- R1: After reset, the reload value, count, control and flag all read as zero, and `irq` is low.
- R2: A write to byte offset 0x0 sets the reload value and also the count to the written data. A write to offset 0x4 sets only the count. The reload value is read back at 0x0.
- R3: Control bit 0 runs the timer and control bits [15:8] hold a divider value D. While running with a nonzero count, the count drops by one every D+1 clock cycles, counted from the edge that took the last configuration write.
- R4: In one-shot mode (control bit 1 = 0), a step from one to zero sets the flag (offset 0xC, bit 0). The count then stays at zero.
- R5: In auto-reload mode (control bit 1 = 1), the step that expires the count loads the reload value instead of zero, and counting continues.
- R6: If a control write raises bit 0 from 0 to 1 with bit 1 set while the count is zero, the count takes the reload value at that edge.
- R7: A write to offset 0xC clears the flag when data bit 0 is 1. It leaves the flag unchanged when data bit 0 is 0. An expiry in the same cycle wins over the clear.
- R8: `irq` is high for exactly one cycle, starting at the edge where the flag goes from 0 to 1. A further expiry while the flag is already set gives no pulse.
- R9: A read of offset 0x4 returns zero while control bit 0 is clear or the count is zero; otherwise it returns the count. While stopped, the count holds its value.
- R10: A zero count with control bit 0 set neither decrements nor expires, unless R6 applies.
- R11: Reads of any offset other than 0x0, 0x4, 0x8 and 0xC return zero, and writes to them change nothing.
- R12: Any write to offsets 0x0, 0x4 or 0x8 restarts the divider period. The next decrement is D+1 cycles after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | One-cycle expiry interrupt pulse |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are known whenever `bus_wr` is high, and that each write strobe lasts exactly one cycle. The bench drives every write for a single cycle from the falling edge and drops the strobe just after the rising edge. The random trials keep start values between 1 and 20 and divider values between 0 and 3, so each expiry falls well inside the run. Between trials the bench first stops the timer and clears the flag, so each trial starts from a known state.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_FLAG   = 4'hC;
  localparam int CTL_RUN_BIT    = 0;
  localparam int CTL_RELOAD_BIT = 1;
  localparam int CTL_DIV_LSB    = 8;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 phase_q <= '0;
    else if (clr || !run)       phase_q <= '0;
    else if (phase_q == div)    phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end

  assign tick = run && !clr && (phase_q == div);

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= div); // R3
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick); // R3
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         auto_rl,
  input  logic [W-1:0] reload_val,
  input  logic         set_cnt,
  input  logic [W-1:0] set_val,
  input  logic         arm,
  output logic [W-1:0] cnt,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  assign expire = tick && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (set_cnt)  cnt <= set_val;
    else if (arm)      cnt <= reload_val;
    else if (expire)   cnt <= auto_rl ? reload_val : '0;
    else if (tick)     cnt <= cnt - ONE;
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !set_cnt && !arm && cnt > ONE) |=> cnt == $past(cnt) - ONE); // R3
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !auto_rl && !set_cnt && !arm) |=> cnt == '0); // R4
  AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && auto_rl && !set_cnt && !arm) |=> cnt == $past(reload_val)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !set_cnt && !arm) |=> $stable(cnt)); // R9
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !set_cnt && !arm) |=> cnt == '0); // R10
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [DATA_W-1:0] reload_q, ctrl_q, cnt;
  logic              flag_q, irq_q, tick, expire;

  wire hit_reload = bus_wr && (bus_addr == OFS_RELOAD);
  wire hit_count  = bus_wr && (bus_addr == OFS_COUNT);
  wire hit_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
  wire hit_flag   = bus_wr && (bus_addr == OFS_FLAG);
  wire cfg_wr     = hit_reload || hit_count || hit_ctrl;
  wire flag_clr   = hit_flag && bus_wdata[0];

  wire             running = ctrl_q[CTL_RUN_BIT] && (cnt != '0);
  wire [DIV_W-1:0] div     = ctrl_q[CTL_DIV_LSB +: DIV_W];
  wire             arm     = hit_ctrl && !ctrl_q[CTL_RUN_BIT]
                             && bus_wdata[CTL_RUN_BIT]
                             && bus_wdata[CTL_RELOAD_BIT] && (cnt == '0);

  cdt_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (running),
    .clr  (cfg_wr),
    .div  (div),
    .tick (tick)
  );

  cdt_counter #(.W(DATA_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .auto_rl   (ctrl_q[CTL_RELOAD_BIT]),
    .reload_val(reload_q),
    .set_cnt   (hit_reload || hit_count),
    .set_val   (bus_wdata),
    .arm       (arm),
    .cnt       (cnt),
    .expire    (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (hit_reload) reload_q <= bus_wdata;
      if (hit_ctrl)   ctrl_q   <= bus_wdata;
      if (expire)        flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      irq_q <= expire && !flag_q;
    end
  end

  assign irq = irq_q;

  always_comb begin
    case (bus_addr)
      OFS_RELOAD: bus_rdata = reload_q;
      OFS_COUNT:  bus_rdata = ctrl_q[CTL_RUN_BIT] ? cnt : '0;
      OFS_CTRL:   bus_rdata = ctrl_q;
      OFS_FLAG:   bus_rdata = {{(DATA_W-1){1'b0}}, flag_q};
      default:    bus_rdata = '0;
    endcase
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8
  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q && !$past(flag_q))); // R8
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !expire) |=> !flag_q); // R7
  AST_FLAG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_clr && !expire) |=> flag_q == $past(flag_q)); // R7
  AST_RELOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_reload |=> $stable(reload_q)); // R11
endmodule

// File: tb/tb_cdt_timer.sv
module tb_cdt_timer;
  localparam logic [3:0] A_RL = 4'h0, A_CNT = 4'h4, A_CTL = 4'h8, A_FLG = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int total = 0;
  int bad = 0;

  cdt_timer dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                 .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic int exp_one(int n, int p, int k);
    int m = k / (p + 1);
    return (m >= n) ? 0 : n - m;
  endfunction

  function automatic int exp_rl(int n, int p, int k);
    int m = k / (p + 1);
    return n - (m % n);
  endfunction

  task automatic trial(input int n, input int p, input bit reload);
    logic [31:0] v;
    int cnt_bad = 0;
    int irq_bad = 0;
    int flg_bad = 0;
    int lim = n * (p + 1);
    int span = reload ? 2 * lim + 3 : lim + 3;
    wr(A_CTL, 0);
    wr(A_FLG, 1);
    wr(A_RL, n);
    wr(A_CTL, (p << 8) | (reload ? 3 : 1));
    for (int k = 1; k <= span; k++) begin
      step();
      rd(A_CNT, v);
      if (v != 32'(reload ? exp_rl(n, p, k) : exp_one(n, p, k))) cnt_bad++;
      if (irq !== (k == lim)) irq_bad++;
      rd(A_FLG, v);
      if (v != 32'(k >= lim)) flg_bad++;
    end
    chk(reload ? "R5 count trace" : "R4 count trace", cnt_bad, 0);
    chk("R8 irq trace", irq_bad, 0);
    chk(reload ? "R5 flag trace" : "R4 flag trace", flg_bad, 0);
  endtask

  initial begin
    #(2_000_000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int seen;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(A_RL, v);  chk("R1 reload", v, 0);
    rd(A_CNT, v); chk("R1 count", v, 0);
    rd(A_CTL, v); chk("R1 ctrl", v, 0);
    rd(A_FLG, v); chk("R1 flag", v, 0);
    chk("R1 irq", irq, 0);

    // R2 / R9: reload write copies, count write only count, disabled reads 0
    wr(A_RL, 5);
    wr(A_CNT, 9);
    rd(A_RL, v);  chk("R2 reload kept", v, 5);
    rd(A_CNT, v); chk("R9 disabled read", v, 0);
    wr(A_CTL, 32'hFF01);
    rd(A_CNT, v); chk("R2 count write", v, 9);
    wr(A_RL, 12);
    rd(A_CNT, v); chk("R2 reload copies", v, 12);

    // R11 unmapped
    wr(4'h1, 32'hAAAA);
    wr(4'h6, 32'h5555);
    rd(A_RL, v);  chk("R11 write ignored", v, 12);
    rd(A_CNT, v); chk("R11 count untouched", v, 12);
    rd(4'h2, v);  chk("R11 read zero", v, 0);
    rd(4'hD, v);  chk("R11 read zero hi", v, 0);

    // R9 stop holds count
    wr(A_CTL, 0);
    repeat (5) step();
    wr(A_CTL, 32'hFF01);
    rd(A_CNT, v); chk("R9 held while stopped", v, 12);

    // R12 divider restart
    wr(A_CTL, 0);
    wr(A_RL, 10);
    wr(A_CTL, 32'h0301);
    wr(A_CTL, 32'h0301);
    repeat (3) step();
    rd(A_CNT, v); chk("R12 no early step", v, 10);
    step();
    rd(A_CNT, v); chk("R12 step after restart", v, 9);

    // R6 arm-copy
    wr(A_CTL, 0);
    wr(A_RL, 7);
    wr(A_CNT, 0);
    wr(A_CTL, 3);
    rd(A_CNT, v); chk("R6 copy on enable", v, 7);
    step();
    rd(A_CNT, v); chk("R3 first step", v, 6);

    // R10 zero count one-shot
    wr(A_CTL, 0);
    wr(A_FLG, 1);
    wr(A_CNT, 0);
    wr(A_CTL, 1);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (irq) seen++;
    end
    rd(A_CNT, v); chk("R10 count stays", v, 0);
    rd(A_FLG, v); chk("R10 no expiry", v, 0);
    chk("R10 no irq", seen, 0);

    // R7 write-one-to-clear
    trial(3, 0, 1'b0);
    wr(A_FLG, 0);
    rd(A_FLG, v); chk("R7 zero keeps", v, 1);
    wr(A_FLG, 2);
    rd(A_FLG, v); chk("R7 bit1 keeps", v, 1);
    wr(A_FLG, 1);
    rd(A_FLG, v); chk("R7 one clears", v, 0);

    // R3 R4 R5 R8 random trials
    for (int t = 0; t < 12; t++)
      trial(1 + int'($urandom % 20), int'($urandom % 4), 1'b0);
    for (int t = 0; t < 8; t++)
      trial(1 + int'($urandom % 20), int'($urandom % 4), 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule